// File: doc/BRIEF.md
# Twenty-Bit Scan Address Register

This block is the address data register of a target-side test access port. It holds a 20-bit memory address covering a 1 MB linear space. The block serves two instructions decoded outside it. One loads an address into the register. The other reads back the address currently on the memory bus. The TAP controller supplies the Capture-DR, Shift-DR and Update-DR state indications, and the block drives TDO and the stored address.

The outgoing and incoming bit orders differ on purpose. On capture, the value presented for shifting out is the low sixteen address bits followed by the top four, each group most significant bit first. A host that only knows a 16-bit address register therefore still reads the lower address half in its expected order. Incoming data arrives most significant bit first in natural order.

A separate collector gathers the TDI bits and counts them. On update, a 20-bit scan replaces the whole address. A 16-bit scan replaces the low half and clears the top four bits. A scan of any other length leaves the address unchanged.

Top module: `jtag_addr20_dr`

## Requirements
- R1: While `trst_n` is low, `addr_out` is zero and `tdo` is zero. The reset also clears the collector's bit count.
- R2: When Capture-DR occurs with only `sel_load` high, the outgoing path takes the stored address. `tdo` then emits `addr_out[15:0]` MSB first, followed by `addr_out[19:16]` MSB first. For example, stored 0xA55AA emits 0x55AA and then 0xA.
- R3: When Capture-DR occurs with `sel_capture` high, the outgoing path takes `bus_addr` in the same order as R2. `sel_capture` takes precedence over `sel_load`.
- R4: TDI is taken most significant bit first. When exactly 20 bits have been shifted since Capture-DR, Update-DR sets `addr_out` to those bits, with the first bit becoming bit 19.
- R5: When exactly 16 bits have been shifted since Capture-DR, Update-DR sets `addr_out[15:0]` to those bits, first bit as bit 15, and sets `addr_out[19:16]` to zero.
- R6: When the shift count is neither 16 nor 20 (for example 12 or 21), Update-DR leaves `addr_out` unchanged.
- R7: While neither `sel_load` nor `sel_capture` is high, capture, shift and update have no effect on `addr_out`, and `tdo` stays zero.
- R8: TDI is sampled on the rising edge of `tck`. `tdo` changes only on the falling edge of `tck`, so its value is the same just before and just after a rising edge.
- R9: At the first falling edge after Shift-DR ends, `tdo` returns to zero.
- R10: If reset is asserted in the middle of a scan, the address is cleared. A later Update-DR that is not preceded by a new Capture-DR leaves the address at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| sel_load | input | 1 | Address-load instruction is active |
| sel_capture | input | 1 | Bus-address capture instruction is active |
| bus_addr | input | 20 | Current memory bus address |
| tdo | output | 1 | Serial data out, updated on falling edge |
| addr_out | output | 20 | Stored address |

## Verification
The bench shifts 0x12568 in while 0xA55AA is stored. A design with natural output order would emit 0xA55AA instead of 0x55AA followed by 0xA. A 16-bit scan after a 20-bit load must zero the top nibble; a design that kept the old nibble would report 0x1BEEF rather than 0x0BEEF. Scans of 12 and 21 bits must leave the address alone; a counter that wraps or takes the last 20 bits would overwrite it. The bench also checks three further cases. A reset in the middle of a scan must not let a stray update apply its stale count. An unselected register must neither update nor drive TDO. TDO must stay steady across the rising edge.

// File: rtl/jtag_addr20_pkg.sv
package jtag_addr20_pkg;
  localparam int ADDR_W = 20;
  localparam int LEG_W  = 16;
  localparam int HI_W   = ADDR_W - LEG_W;
  localparam int CNT_W  = $clog2(ADDR_W + 2);
  localparam int CNT_SAT = ADDR_W + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Outgoing order: low part first, then the high nibble.
  function automatic addr_t fn_out_order(input addr_t a);
    return {a[LEG_W-1:0], a[ADDR_W-1:LEG_W]};
  endfunction

  // A legacy-width load clears the upper bits.
  function automatic addr_t fn_legacy_fill(input addr_t rx);
    addr_t r;
    r = '0;
    r[LEG_W-1:0] = rx[LEG_W-1:0];
    return r;
  endfunction

  // Saturating bit counter, so over-long scans never alias to a valid length.
  function automatic cnt_t fn_cnt_next(input cnt_t c);
    if (c >= cnt_t'(CNT_SAT)) return cnt_t'(CNT_SAT);
    return c + cnt_t'(1);
  endfunction
endpackage

// File: rtl/a20_tx_path.sv
module a20_tx_path
  import jtag_addr20_pkg::*;
(
  input  logic  tck,
  input  logic  trst_n,
  input  logic  dr_sel,
  input  logic  capture_dr,
  input  logic  shift_dr,
  input  logic  src_bus,
  input  addr_t bus_addr,
  input  addr_t stored,
  output addr_t tx_word,
  output logic  tdo
);
  addr_t cap_src;

  always_comb cap_src = src_bus ? bus_addr : stored;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tx_word <= '0;
    end else if (dr_sel && capture_dr) begin
      tx_word <= fn_out_order(cap_src);
    end else if (dr_sel && shift_dr) begin
      tx_word <= {tx_word[ADDR_W-2:0], 1'b0};
    end
  end

  // Output bit presented on the falling edge only.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= (dr_sel && shift_dr) ? tx_word[ADDR_W-1] : 1'b0;
  end
endmodule

// File: rtl/a20_rx_collect.sv
module a20_rx_collect
  import jtag_addr20_pkg::*;
(
  input  logic  tck,
  input  logic  trst_n,
  input  logic  dr_sel,
  input  logic  capture_dr,
  input  logic  shift_dr,
  input  logic  update_dr,
  input  logic  tdi,
  output addr_t rx_word,
  output cnt_t  bit_cnt,
  output logic  upd_full,
  output logic  upd_legacy
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rx_word <= '0;
      bit_cnt <= '0;
    end else if (dr_sel && capture_dr) begin
      bit_cnt <= '0;
    end else if (dr_sel && shift_dr) begin
      rx_word <= {rx_word[ADDR_W-2:0], tdi};
      bit_cnt <= fn_cnt_next(bit_cnt);
    end
  end

  always_comb begin
    upd_full   = dr_sel && update_dr && (bit_cnt == cnt_t'(ADDR_W));
    upd_legacy = dr_sel && update_dr && (bit_cnt == cnt_t'(LEG_W));
  end
endmodule

// File: rtl/a20_addr_hold.sv
module a20_addr_hold
  import jtag_addr20_pkg::*;
(
  input  logic  tck,
  input  logic  trst_n,
  input  logic  upd_full,
  input  logic  upd_legacy,
  input  addr_t rx_word,
  output addr_t addr_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         addr_q <= '0;
    else if (upd_full)   addr_q <= rx_word;
    else if (upd_legacy) addr_q <= fn_legacy_fill(rx_word);
  end
endmodule

// File: rtl/jtag_addr20_dr.sv
module jtag_addr20_dr
  import jtag_addr20_pkg::*;
(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              sel_load,
  input  logic              sel_capture,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              tdo,
  output logic [ADDR_W-1:0] addr_out
);
  logic  dr_sel;
  logic  upd_full, upd_legacy;
  addr_t rx_word, tx_word, addr_q;
  cnt_t  bit_cnt;

  assign dr_sel   = sel_load | sel_capture;
  assign addr_out = addr_q;

  a20_tx_path u_tx (
    .tck(tck), .trst_n(trst_n), .dr_sel(dr_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .src_bus(sel_capture), .bus_addr(bus_addr),
    .stored(addr_q), .tx_word(tx_word), .tdo(tdo)
  );

  a20_rx_collect u_rx (
    .tck(tck), .trst_n(trst_n), .dr_sel(dr_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
    .rx_word(rx_word), .bit_cnt(bit_cnt), .upd_full(upd_full), .upd_legacy(upd_legacy)
  );

  a20_addr_hold u_hold (
    .tck(tck), .trst_n(trst_n), .upd_full(upd_full), .upd_legacy(upd_legacy),
    .rx_word(rx_word), .addr_q(addr_q)
  );
endmodule

// File: rtl/jtag_addr20_chk.sv
module jtag_addr20_chk
  import jtag_addr20_pkg::*;
(
  input logic  tck,
  input logic  trst_n,
  input logic  capture_dr,
  input logic  update_dr,
  input logic  sel_load,
  input logic  sel_capture,
  input addr_t bus_addr,
  input logic  tdo,
  input addr_t addr_out,
  input logic  dr_sel,
  input logic  upd_full,
  input logic  upd_legacy,
  input addr_t rx_word,
  input addr_t tx_word
);
  always @(posedge tck) begin
    if (!trst_n) AST_RESET_CLEAR: assert (addr_out == '0 && tdo == 1'b0); // R1
  end

  AST_CAPTURE_STORED: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel_load && !sel_capture) |=> tx_word == fn_out_order($past(addr_out))); // R2
  AST_CAPTURE_BUS: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel_capture) |=> tx_word == fn_out_order($past(bus_addr))); // R3
  AST_FULL_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
    upd_full |=> addr_out == $past(rx_word)); // R4
  AST_LEGACY_HI_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    upd_legacy |=> addr_out[ADDR_W-1:LEG_W] == '0); // R5
  AST_LEGACY_LO: assert property (@(posedge tck) disable iff (!trst_n)
    upd_legacy |=> addr_out[LEG_W-1:0] == $past(rx_word[LEG_W-1:0])); // R5
  AST_ODD_IGNORED: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && !upd_full && !upd_legacy) |=> $stable(addr_out)); // R6
  AST_ONE_UPDATE_KIND: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({upd_full, upd_legacy})); // R6
  AST_UNSEL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    !dr_sel |=> $stable(addr_out)); // R7
endmodule

bind jtag_addr20_dr jtag_addr20_chk chk_i (
  .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .update_dr(update_dr),
  .sel_load(sel_load), .sel_capture(sel_capture), .bus_addr(bus_addr),
  .tdo(tdo), .addr_out(addr_out), .dr_sel(dr_sel), .upd_full(upd_full),
  .upd_legacy(upd_legacy), .rx_word(rx_word), .tx_word(tx_word)
);

// File: tb/jtag_addr20_dr_tb_top.sv
module jtag_addr20_dr_tb_top;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic sel_load = 1'b0, sel_capture = 1'b0;
  logic [19:0] bus_addr = '0;
  logic tdo;
  logic [19:0] addr_out;
  int n_checks = 0;
  int n_fail = 0;

  always #4 tck = ~tck;

  jtag_addr20_dr dut_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .sel_load(sel_load),
    .sel_capture(sel_capture), .bus_addr(bus_addr), .tdo(tdo), .addr_out(addr_out)
  );

  // Expected outgoing order, written as a rotation.
  function automatic logic [19:0] rot_out(input logic [19:0] a);
    logic [39:0] d;
    d = {a, a};
    return d[35:16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Full DR scan: capture, n shift bits, update.
  task automatic scan(input int n, input logic [31:0] din, input logic sl, input logic sc,
                      output logic [31:0] dout, output logic edge_ok);
    logic b;
    sel_load = sl; sel_capture = sc;
    capture_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0; shift_dr = 1'b1;
    dout = '0; edge_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = din[n-1-i];
      @(negedge tck); #1;
      b = tdo;
      dout = {dout[30:0], b};
      @(posedge tck); #1;
      if (tdo !== b) edge_ok = 1'b0;
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 addr after reset", 32'(addr_out), 32'h0);
    chk("R1 tdo after reset", 32'(tdo), 32'h0);
  endtask

  task automatic t_full_and_order;
    logic [31:0] d; logic ok;
    scan(20, 32'hA55AA, 1'b1, 1'b0, d, ok);
    chk("R4 20-bit load", 32'(addr_out), 32'hA55AA);
    scan(20, 32'h12568, 1'b1, 1'b0, d, ok);
    chk("R2 out order low16 then hi4", d, 32'(rot_out(20'hA55AA)));
    chk("R2 example 0x55AA then 0xA", d, 32'h55AAA);
    chk("R4 new address", 32'(addr_out), 32'h12568);
    chk("R8 tdo steady across rising edge", 32'(ok), 32'h1);
    @(negedge tck); #1;
    chk("R9 tdo idle after shift", 32'(tdo), 32'h0);
  endtask

  task automatic t_legacy;
    logic [31:0] d; logic ok;
    scan(16, 32'hBEEF, 1'b1, 1'b0, d, ok);
    chk("R2 legacy read gets bit15 first", d, 32'h2568);
    chk("R5 16-bit load clears top", 32'(addr_out), 32'h0BEEF);
  endtask

  task automatic t_bus_capture;
    logic [31:0] d; logic ok;
    bus_addr = 20'h3C5E1;
    scan(20, 32'h7F00D, 1'b1, 1'b1, d, ok);
    chk("R3 bus capture order", d, 32'(rot_out(20'h3C5E1)));
    chk("R4 load under capture instr", 32'(addr_out), 32'h7F00D);
  endtask

  task automatic t_odd_lengths;
    logic [31:0] d; logic ok;
    scan(12, 32'hFFF, 1'b1, 1'b0, d, ok);
    chk("R6 12-bit scan ignored", 32'(addr_out), 32'h7F00D);
    scan(21, 32'h1FFFFF, 1'b1, 1'b0, d, ok);
    chk("R6 21-bit scan ignored", 32'(addr_out), 32'h7F00D);
  endtask

  task automatic t_unselected;
    logic [31:0] d; logic ok;
    scan(20, 32'hFFFFF, 1'b0, 1'b0, d, ok);
    chk("R7 unselected addr held", 32'(addr_out), 32'h7F00D);
    chk("R7 unselected tdo quiet", d, 32'h0);
    scan(16, 32'h1234, 1'b0, 1'b0, d, ok);
    chk("R7 unselected 16-bit held", 32'(addr_out), 32'h7F00D);
  endtask

  task automatic t_reset_mid;
    sel_load = 1'b1; sel_capture = 1'b0;
    capture_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0; shift_dr = 1'b1; tdi = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(posedge tck); #1;
    end
    shift_dr = 1'b0;
    trst_n = 1'b0; #2;
    chk("R10 reset clears addr mid-scan", 32'(addr_out), 32'h0);
    trst_n = 1'b1;
    update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0;
    chk("R10 stale update ignored", 32'(addr_out), 32'h0);
  endtask

  initial begin
    #(8 * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge tck);
    #1;
    t_reset();
    trst_n = 1'b1;
    @(posedge tck); #1;
    t_full_and_order();
    t_legacy();
    t_bus_capture();
    t_odd_lengths();
    t_unselected();
    t_reset_mid();
    repeat (2) @(posedge tck);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule